// File: doc/BRIEF.md
# Four-mode built-in test register

This block is an n-bit register that serves both the functional path and on-chip self-test. A two-bit mode code, sampled at each rising clock edge, picks one of four behaviours. The register can be an ordinary parallel register. It can be a serial shift chain for loading and unloading. It can be a free-running linear feedback shift register that produces test patterns. It can be a multiple-input signature register that folds the parallel inputs into a running signature.

In a self-test setup, one copy of the block drives patterns into a piece of logic while a second copy compacts that logic's responses. The roles can then be swapped for the next piece of logic. The register has no reset input. It is cleared by shifting zeros in through the serial chain. A finished signature is read out serially by switching to the shift code and clocking, because the serial output always shows the last stage. The feedback taps are a parameter. By default every stage feeds back, which gives the polynomial 1 + x + ... + x^n.

Top module: `test_observer_reg`

## Requirements
- R1: With mode code {mode_b1,mode_b2} = 2'b00, each edge moves stage i-1 into stage i, and scan_in enters stage 0 (bit 0 of par_out).
- R2: scan_out always equals the last stage, par_out[WIDTH-1], in every mode, so a value can be read serially after switching to code 2'b00.
- R3: With code 2'b10, each edge loads par_in into all stages unchanged.
- R4: With code 2'b01, each edge shifts the stages up by one and stage 0 takes the XOR of the stages whose TAPS bit is 1. par_in and scan_in have no effect.
- R5: With code 2'b11, each edge takes the R4 next value and XORs it bitwise with par_in.
- R6: Under code 2'b01, a register holding all zeros stays at all zeros.
- R7: WIDTH edges under code 2'b00 with scan_in low leave the register all zeros, whatever it held before. This is the only way to clear it.
- R8: Overriding TAPS changes which stages feed stage 0 in codes 2'b01 and 2'b11. For example, TAPS = 8'hB8 uses only stages 3, 4, 5 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| mode_b1 | input | 1 | Upper mode-code bit |
| mode_b2 | input | 1 | Lower mode-code bit |
| par_in | input | WIDTH | Parallel data from upstream logic |
| scan_in | input | 1 | Serial input into stage 0 |
| par_out | output | WIDTH | Parallel register contents |
| scan_out | output | 1 | Serial output, the last stage |

## Verification
Two states are hard to reach from the ports. The first is a known state, since the block has no reset. The bench reaches it by shifting WIDTH zeros in before any checks. The second is a non-zero seed for pattern generation, and the bench gets one through the capture or shift codes. The zero-lock case is reached on purpose by running the generator straight after a clear. Signature readback is exercised by compacting in code 2'b11 and then shifting the result out, comparing scan_out bit by bit. Two instances with different taps run on the same stimulus, so any error in tap selection shows up as a difference between them.

// File: rtl/tobs_pkg.sv
package tobs_pkg;

    // Mode code {b1,b2}; the encoding is fixed by the requirements.
    typedef enum logic [1:0] {
        MODE_SHIFT   = 2'b00,
        MODE_PATGEN  = 2'b01,
        MODE_CAPTURE = 2'b10,
        MODE_SIGN    = 2'b11
    } tobs_mode_e;

endpackage

// File: rtl/tobs_feedback.sv
module tobs_feedback #(
    parameter int                 WIDTH = 8,
    parameter logic [WIDTH-1:0]   TAPS  = '1
) (
    input  logic [WIDTH-1:0] cells,
    output logic             fb_bit
);
    // Parity of the stages selected by the tap mask.
    logic [WIDTH-1:0] tapped;

    always_comb begin
        tapped = cells & TAPS;
        fb_bit = ^tapped;
    end
endmodule

// File: rtl/tobs_cell_mux.sv
module tobs_cell_mux
    import tobs_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  tobs_mode_e       mode,
    input  logic [WIDTH-1:0] cells,
    input  logic [WIDTH-1:0] par_in,
    input  logic             head_bit,
    output logic [WIDTH-1:0] cells_next
);
    // Each stage picks its next value on its own; stage 0 takes the head bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic shifted;
        if (i == 0) begin : g_first
            assign shifted = head_bit;
        end else begin : g_rest
            assign shifted = cells[i-1];
        end

        always_comb begin
            unique case (mode)
                MODE_SHIFT:   cells_next[i] = shifted;
                MODE_PATGEN:  cells_next[i] = shifted;
                MODE_CAPTURE: cells_next[i] = par_in[i];
                MODE_SIGN:    cells_next[i] = shifted ^ par_in[i];
                default:      cells_next[i] = shifted;
            endcase
        end
    end
endmodule

// File: rtl/test_observer_reg.sv
module test_observer_reg
    import tobs_pkg::*;
#(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS  = '1
) (
    input  logic             clk,
    input  logic             mode_b1,
    input  logic             mode_b2,
    input  logic [WIDTH-1:0] par_in,
    input  logic             scan_in,
    output logic [WIDTH-1:0] par_out,
    output logic             scan_out
);
    localparam int LAST = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] cells;
    } tobs_state_t;

    tobs_state_t      st_d, st_q;
    tobs_mode_e       mode;
    logic             fb_bit;
    logic             head_bit;
    logic [WIDTH-1:0] cells_next;

    assign mode = tobs_mode_e'({mode_b1, mode_b2});

    tobs_feedback #(
        .WIDTH (WIDTH),
        .TAPS  (TAPS)
    ) u_feedback (
        .cells  (st_q.cells),
        .fb_bit (fb_bit)
    );

    // The serial input feeds stage 0 only in shift mode; otherwise the feedback does.
    assign head_bit = (mode == MODE_SHIFT) ? scan_in : fb_bit;

    tobs_cell_mux #(
        .WIDTH (WIDTH)
    ) u_cell_mux (
        .mode       (mode),
        .cells      (st_q.cells),
        .par_in     (par_in),
        .head_bit   (head_bit),
        .cells_next (cells_next)
    );

    always_comb begin
        st_d       = st_q;
        st_d.cells = cells_next;
    end

    // No reset: clearing is done by shifting zeros through the chain.
    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign par_out  = st_q.cells;
    assign scan_out = st_q.cells[LAST];
endmodule

// File: rtl/test_observer_chk.sv
module test_observer_chk
    import tobs_pkg::*;
#(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS  = '1
) (
    input logic             clk,
    input logic             mode_b1,
    input logic             mode_b2,
    input logic [WIDTH-1:0] par_in,
    input logic             scan_in,
    input logic [WIDTH-1:0] par_out,
    input logic             scan_out
);
    logic [1:0] code;
    logic       armed_q;
    logic       inactive;

    assign code = {mode_b1, mode_b2};

    // Checks start once the register holds a known value for two edges in a row.
    always_ff @(posedge clk) begin
        armed_q <= !$isunknown(par_out);
    end
    assign inactive = (armed_q !== 1'b1) || $isunknown(par_out);

    // R1
    shift_move_chk: assert property (@(posedge clk) disable iff (inactive)
        code == MODE_SHIFT |=> par_out == {$past(par_out[WIDTH-2:0]), $past(scan_in)});

    // R2
    serial_tail_chk: assert property (@(posedge clk) disable iff (inactive)
        code == MODE_SHIFT |=> scan_out == $past(par_out[WIDTH-2]));

    // R3
    capture_load_chk: assert property (@(posedge clk) disable iff (inactive)
        code == MODE_CAPTURE |=> par_out == $past(par_in));

    // R4
    patgen_step_chk: assert property (@(posedge clk) disable iff (inactive)
        code == MODE_PATGEN |=>
            par_out == {$past(par_out[WIDTH-2:0]), ^($past(par_out) & TAPS)});

    // R5
    sign_fold_chk: assert property (@(posedge clk) disable iff (inactive)
        code == MODE_SIGN |=>
            par_out == ({$past(par_out[WIDTH-2:0]), ^($past(par_out) & TAPS)} ^ $past(par_in)));

    // R6
    zero_lock_chk: assert property (@(posedge clk) disable iff (inactive)
        (code == MODE_PATGEN && par_out == '0) |=> par_out == '0);
endmodule

bind test_observer_reg test_observer_chk #(
    .WIDTH (WIDTH),
    .TAPS  (TAPS)
) u_chk (
    .clk      (clk),
    .mode_b1  (mode_b1),
    .mode_b2  (mode_b2),
    .par_in   (par_in),
    .scan_in  (scan_in),
    .par_out  (par_out),
    .scan_out (scan_out)
);

// File: tb/test_observer_reg_bench.sv
`timescale 1ns/1ps
module test_observer_reg_bench;
    localparam int         W        = 8;
    localparam logic [W-1:0] TAPS_A = '1;
    localparam logic [W-1:0] TAPS_B = 8'hB8;

    logic         clk = 1'b0;
    logic         mode_b1 = 1'b0, mode_b2 = 1'b0;
    logic [W-1:0] par_in = '0;
    logic         scan_in = 1'b0;
    logic [W-1:0] out_a, out_b;
    logic         so_a, so_b;

    logic [W-1:0] exp_a, exp_b;
    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    test_observer_reg #(.WIDTH(W), .TAPS(TAPS_A)) u_test_observer_reg (
        .clk(clk), .mode_b1(mode_b1), .mode_b2(mode_b2), .par_in(par_in),
        .scan_in(scan_in), .par_out(out_a), .scan_out(so_a));

    test_observer_reg #(.WIDTH(W), .TAPS(TAPS_B)) u_test_observer_reg_alt (
        .clk(clk), .mode_b1(mode_b1), .mode_b2(mode_b2), .par_in(par_in),
        .scan_in(scan_in), .par_out(out_b), .scan_out(so_b));

    // Next value from the requirements R1, R3, R4, R5.
    function automatic logic [W-1:0] model_next(input logic [W-1:0] q, input logic [1:0] m,
                                                input logic [W-1:0] pi, input logic si,
                                                input logic [W-1:0] taps);
        logic fb;
        fb = ^(q & taps);
        case (m)
            2'b00:   return {q[W-2:0], si};
            2'b01:   return {q[W-2:0], fb};
            2'b10:   return pi;
            default: return {q[W-2:0], fb} ^ pi;
        endcase
    endfunction

    function automatic string req_of(input logic [1:0] m);
        case (m)
            2'b00:   return "R1";
            2'b01:   return "R4";
            2'b10:   return "R3";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one edge on both instances and compare both against the model.
    task automatic step(input logic [1:0] m, input logic [W-1:0] pi, input logic si,
                        input string tag);
        {mode_b1, mode_b2} = m;
        par_in  = pi;
        scan_in = si;
        exp_a = model_next(exp_a, m, pi, si, TAPS_A);
        exp_b = model_next(exp_b, m, pi, si, TAPS_B);
        @(posedge clk);
        #2;
        check(tag, out_a, exp_a);
        check({"R8/", tag}, out_b, exp_b);
        check("R2", {7'd0, so_a}, {7'd0, exp_a[W-1]});
    endtask

    initial begin
        void'($urandom(32'd2718));
        #2;
        // Load ones, then clear by shifting zeros (R7); no reset exists.
        exp_a = '1; exp_b = '1;
        {mode_b1, mode_b2} = 2'b10; par_in = '1;
        @(posedge clk); #2;
        for (int i = 0; i < W; i++) step(2'b00, 8'h5A, 1'b0, "R1");
        check("R7", out_a, '0);
        check("R7", out_b, '0);

        // R6: zero lock in pattern mode even with busy par_in.
        for (int i = 0; i < 12; i++) step(2'b01, 8'(i * 37 + 1), 1'b1, "R6");

        // Seed serially with 1,0,1,1 pattern, then generate patterns (R4).
        for (int i = 0; i < W; i++) step(2'b00, '0, 1'(i % 3 != 1), "R1");
        for (int i = 0; i < 20; i++) step(2'b01, 8'($urandom), 1'($urandom), "R4");

        // Signature compaction, then serial readback through scan_out (R5, R2).
        for (int i = 0; i < 16; i++) step(2'b11, 8'($urandom), 1'b0, "R5");
        for (int i = 0; i < W; i++) step(2'b00, '0, 1'b0, "R2");

        // Capture corner values (R3).
        step(2'b10, 8'h00, 1'b1, "R3");
        step(2'b10, 8'hFF, 1'b0, "R3");
        step(2'b10, 8'h80, 1'b0, "R3");

        // Random mix of all modes.
        for (int i = 0; i < 600; i++) begin
            logic [1:0] m;
            m = 2'($urandom);
            step(m, 8'($urandom), 1'($urandom), req_of(m));
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule